// File: doc/BRIEF.md
# Split Carry-Select Integer ALU

This block is a 32-bit integer arithmetic and logic unit for the execute stage of a small pipelined processor. It takes two operands and a 3-bit operation code. It returns a 32-bit result, a carry-out and a zero flag. The unit adds and subtracts, and it also forms bitwise AND, OR and XOR. It contains no storage, so its outputs follow its inputs within the same cycle.

The operand conditioner sits ahead of the adder and prepares the second operand for the requested operation. For subtraction it complements that operand and raises the incoming carry. The adder is split into two parts. The lower 25 bits come from a chain of lookahead groups: five groups of four bits, then a final group of five bits. The upper 7 bits are formed twice in parallel, once assuming an incoming carry of zero and once assuming one. The carry leaving the lower section picks which of the two copies is used. For bitwise operations the result comes from a separate bitwise unit, and the adder output is discarded.

Top module: `alu_csel_top`

## Requirements
- R1: With op code 3'd0 (add), result equals (A + B) mod 2^32 and carry equals bit 32 of the unbounded sum.
- R2: With op code 3'd1 (subtract), result equals A + ~B + 1 mod 2^32, and carry is bit 32 of that sum, so carry is 1 exactly when A >= B as unsigned values.
- R3: With op codes 3'd2, 3'd3 and 3'd4, result is A & B, A | B and A ^ B respectively, and carry is 0.
- R4: Op codes 3'd5, 3'd6 and 3'd7 give result 0 and carry 0, and so zero is 1.
- R5: The zero output is 1 exactly when all 32 result bits are 0, for every op code.
- R6: A carry produced in the lower 25 bits propagates into bits 25 to 31. For example, add with A = 32'h01FF_FFFF and B = 1 gives 32'h0200_0000 with carry 0.
- R7: A carry out of bit 31 wraps the result. Add with A = 32'hFFFF_FFFF and B = 1 gives result 0, carry 1 and zero 1.
- R8: The unit is purely combinational. A change on A, B or the op code shows up on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, conditioned per operation |
| op_i | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5-7 unused |
| result_o | output | 32 | Result of the selected operation |
| carry_o | output | 1 | Carry out of bit 31 for add and subtract, otherwise 0 |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench concentrates on carries that cross the seam between the lookahead section and the duplicated upper section. If the select used the wrong copy there, or inverted the select, the upper seven bits would come out off by one exactly when the low 25 bits overflow.

Subtraction is checked where the operands are equal and where the result would be negative. These cases expose a missing incoming carry, which gives an off-by-one difference, and a borrow flag of the wrong polarity. Wrap-around at bit 31 and the unused op codes catch a carry leaking into the logic operations and a zero flag computed from the adder instead of the final result. Random operands across all op codes cover errors inside individual lookahead groups, including the wider final group.

// File: rtl/alu_csel_pkg.sv
`timescale 1ns/1ps
package alu_csel_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  function automatic logic is_arith(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction
endpackage

// File: rtl/cla_group.sv
`timescale 1ns/1ps
// One lookahead group: every internal carry is a flat sum of products
// of generate/propagate terms, not a ripple through neighbours.
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  assign gen  = a_i & b_i;
  assign prop = a_i ^ b_i;

  always_comb begin : lookahead
    logic acc;
    logic run;
    carry[0] = cin_i;
    for (int i = 0; i < W; i++) begin
      acc = 1'b0;
      run = 1'b1;
      for (int j = i; j >= 0; j--) begin
        acc = acc | (run & gen[j]);
        run = run & prop[j];
      end
      carry[i+1] = acc | (run & cin_i);
    end
  end

  assign sum_o  = prop ^ carry[W-1:0];
  assign cout_o = carry[W];
endmodule

// File: rtl/low_adder.sv
`timescale 1ns/1ps
// Lower section: chained lookahead groups; the last group absorbs the remainder.
module low_adder #(
  parameter int LOW_W   = 25,
  parameter int GROUP_W = 4
) (
  input  logic [LOW_W-1:0] a_i,
  input  logic [LOW_W-1:0] b_i,
  input  logic             cin_i,
  output logic [LOW_W-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP   = LOW_W / GROUP_W;
  localparam int LAST_W = LOW_W - GROUP_W * (NGRP - 1);

  logic [NGRP:0] chain;
  assign chain[0] = cin_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int GW  = (g == NGRP - 1) ? LAST_W : GROUP_W;
    localparam int LSB = g * GROUP_W;
    cla_group #(.W(GW)) u_grp (
      .a_i   (a_i[LSB +: GW]),
      .b_i   (b_i[LSB +: GW]),
      .cin_i (chain[g]),
      .sum_o (sum_o[LSB +: GW]),
      .cout_o(chain[g+1])
    );
  end

  assign cout_o = chain[NGRP];
endmodule

// File: rtl/upper_select.sv
`timescale 1ns/1ps
// Upper section: two speculative adders, one picked by the lower carry.
module upper_select #(
  parameter int HI_W = 7
) (
  input  logic [HI_W-1:0] a_i,
  input  logic [HI_W-1:0] b_i,
  input  logic            sel_i,
  output logic [HI_W-1:0] sum_o,
  output logic            cout_o
);
  logic [HI_W-1:0] sum_c0, sum_c1;
  logic            co_c0, co_c1;

  cla_group #(.W(HI_W)) u_c0 (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(sum_c0), .cout_o(co_c0)
  );
  cla_group #(.W(HI_W)) u_c1 (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b1), .sum_o(sum_c1), .cout_o(co_c1)
  );

  assign sum_o  = sel_i ? sum_c1 : sum_c0;
  assign cout_o = sel_i ? co_c1  : co_c0;
endmodule

// File: rtl/operand_mod.sv
`timescale 1ns/1ps
// Conditions the second operand and the incoming carry per operation.
module operand_mod
  import alu_csel_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] b_mod_o,
  output logic             cin_o
);
  always_comb begin
    if (op_i == OP_SUB) begin
      b_mod_o = ~b_i;
      cin_o   = 1'b1;
    end else begin
      b_mod_o = b_i;
      cin_o   = 1'b0;
    end
  end
endmodule

// File: rtl/logic_unit.sv
`timescale 1ns/1ps
// Bitwise operations; returns zero for any code it does not own.
module logic_unit
  import alu_csel_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_csel_top.sv
`timescale 1ns/1ps
module alu_csel_top
  import alu_csel_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int LOW_W   = 25,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o
);
  localparam int HI_W = WIDTH - LOW_W;

  logic [WIDTH-1:0] b_mod;
  logic             cin;
  logic [LOW_W-1:0] low_sum;
  logic             low_co;
  logic [HI_W-1:0]  hi_sum;
  logic             hi_co;
  logic [WIDTH-1:0] logic_res;
  logic             arith;

  operand_mod #(.WIDTH(WIDTH)) u_opmod (
    .b_i(b_i), .op_i(op_i), .b_mod_o(b_mod), .cin_o(cin)
  );

  low_adder #(.LOW_W(LOW_W), .GROUP_W(GROUP_W)) u_low (
    .a_i(a_i[LOW_W-1:0]), .b_i(b_mod[LOW_W-1:0]), .cin_i(cin),
    .sum_o(low_sum), .cout_o(low_co)
  );

  upper_select #(.HI_W(HI_W)) u_hi (
    .a_i(a_i[WIDTH-1:LOW_W]), .b_i(b_mod[WIDTH-1:LOW_W]), .sel_i(low_co),
    .sum_o(hi_sum), .cout_o(hi_co)
  );

  logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(logic_res)
  );

  assign arith    = is_arith(op_i);
  assign result_o = arith ? {hi_sum, low_sum} : logic_res;
  assign carry_o  = arith & hi_co;
  assign zero_o   = ~|result_o;
endmodule

// File: rtl/alu_csel_chk.sv
`timescale 1ns/1ps
module alu_csel_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             zero_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      assert_zero_flag_R5: assert (zero_o == (result_o == '0))
        else $error("zero flag disagrees with result");
      if (op_i == 3'd0) begin
        assert_add_sum_R1: assert ({carry_o, result_o} ==
                                   ({1'b0, a_i} + {1'b0, b_i}))
          else $error("add mismatch");
      end else if (op_i == 3'd1) begin
        assert_sub_diff_R2: assert ({carry_o, result_o} ==
                                    ({1'b0, a_i} + {1'b0, ~b_i} + (WIDTH+1)'(1)))
          else $error("subtract mismatch");
      end else if (op_i <= 3'd4) begin
        assert_logic_nocarry_R3: assert (!carry_o)
          else $error("carry set on bitwise op");
      end else begin
        assert_unused_code_R4: assert (result_o == '0 && !carry_o)
          else $error("unused code produced output");
      end
    end
  end
endmodule

bind alu_csel_top alu_csel_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
);

// File: tb/tb_alu_csel_top.sv
`timescale 1ns/1ps
module tb_alu_csel_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] a, b;
  logic [2:0]  op;
  logic [31:0] result;
  logic        carry, zero;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] a, b;
    logic [2:0]  op;
    logic [31:0] r;
    logic        c;
    logic        z;
    string       tag;
  } item_t;

  item_t sb[$];

  alu_csel_top dut (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(result), .carry_o(carry), .zero_o(zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic item_t model(input logic [31:0] x, input logic [31:0] y,
                                  input logic [2:0] o, input string t);
    item_t it;
    logic [32:0] s;
    it.a = x; it.b = y; it.op = o; it.tag = t;
    it.c = 1'b0;
    case (o)
      3'd0: begin s = {1'b0, x} + {1'b0, y};          it.r = s[31:0]; it.c = s[32]; end
      3'd1: begin s = {1'b0, x} + {1'b0, ~y} + 33'd1; it.r = s[31:0]; it.c = s[32]; end
      3'd2: it.r = x & y;
      3'd3: it.r = x | y;
      3'd4: it.r = x ^ y;
      default: it.r = 32'd0;
    endcase
    it.z = (it.r == 32'd0);
    return it;
  endfunction

  task automatic drive(input logic [31:0] x, input logic [31:0] y,
                       input logic [2:0] o, input string t);
    @(posedge clk);
    a  = x;
    b  = y;
    op = o;
    sb.push_back(model(x, y, o, t));
  endtask

  // Monitor: compares one scoreboard entry mid-cycle after each drive.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      n_vec++;
      if (result !== e.r || carry !== e.c || zero !== e.z) begin
        n_fail++;
        $display("FAIL %s op=%0d a=%h b=%h: got r=%h c=%b z=%b expected r=%h c=%b z=%b",
                 e.tag, e.op, e.a, e.b, result, carry, zero, e.r, e.c, e.z);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; op = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: outputs follow inputs without a clock edge
    @(negedge clk);
    a = 32'd5; b = 32'd3; op = 3'd0;
    #1;
    n_vec++;
    if (result !== 32'd8 || carry !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: got r=%h c=%b expected r=%h c=%b", result, carry, 32'd8, 1'b0);
    end

    // Reset/idle state: zero operands give zero result (R5)
    drive(32'd0, 32'd0, 3'd0, "R5");

    // R6: carry crossing the lower/upper seam
    drive(32'h01FF_FFFF, 32'd1, 3'd0, "R6");
    drive(32'h01FF_FFFF, 32'h01FF_FFFF, 3'd0, "R6");
    drive(32'h0200_0000, 32'd1, 3'd1, "R6");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'd0, "R7");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd0, "R1");
    drive(32'h8000_0000, 32'h8000_0000, 3'd0, "R7");

    // R2 corners
    drive(32'h1234_5678, 32'h1234_5678, 3'd1, "R2");
    drive(32'd0, 32'd1, 3'd1, "R2");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'd1, "R2");

    // R3 corners
    drive(32'hFFFF_0000, 32'h00FF_FF00, 3'd2, "R3");
    drive(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'd3, "R3");
    drive(32'hA5A5_A5A5, 32'hA5A5_A5A5, 3'd4, "R3");

    // R4 unused codes
    for (int c = 5; c < 8; c++)
      drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, c[2:0], "R4");

    // Random operands on every code
    for (int k = 0; k < 400; k++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      drive($urandom, $urandom, o,
            (o == 3'd0) ? "R1" : (o == 3'd1) ? "R2" : (o <= 3'd4) ? "R3" : "R4");
    end

    // Random seam-stressing adds: low 25 bits saturated
    for (int k = 0; k < 100; k++)
      drive($urandom | 32'h01FF_FFFF, $urandom_range(1, 255), 3'd0, "R6");

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule